// File: doc/BRIEF.md
# Framed Serial PCM Codec Port

This block sits between a voice converter and a signal processor. It runs on one bit clock and has two frame syncs, one for each direction. When the transmit sync rises, the port takes one converted sample and sends it out as a 16-bit word, most significant bit first. The word is the 13-bit sample followed by three zero bits. When the receive sync rises, the port collects 16 bits from the serial input and splits them into a 13-bit PCM sample and a 3-bit attenuation code. It presents both with a one-cycle strobe.

The transmit side runs on rising clock edges and the receive side samples on falling edges. Each side is a small state machine with two states. The transmit machine has TX_IDLE and TX_SHIFT. Its transitions are TX_IDLE to TX_SHIFT on a sync rise while powered up, and TX_SHIFT back to TX_IDLE after the sixteenth bit or on power-down. The receive machine has RX_IDLE and RX_SHIFT. Its transitions are RX_IDLE to RX_SHIFT on a sync rise while powered up, and RX_SHIFT back to RX_IDLE after the sixteenth captured bit or on power-down.

A frame lasts 256 bit clocks. Outside the 16 data slots the serial output is released and serial input is ignored. A mute input forces an all-zero transmit word. An active-low power-down input stops both directions and releases the output.

Top module: `pcm_serial_port`

## Requirements
- R1: On the first rising clock edge at which `fsx` is sampled high after being low, `dout` carries word bit 15 (the sign bit), and each of the next 15 rising edges drives the next lower bit, down to bit 0.
- R2: The transmit word is `{tx_sample[12:0], 3'b000}`: bits 15..3 hold the sample and bits 2..0 are always zero.
- R3: `dout_oe` is high for exactly the 16 clock cycles that follow the frame-start edge. A sync that stays high for several cycles starts only one frame.
- R4: On the first falling clock edge at which `fsr` is sampled high after being low, `din` is captured as word bit 15, and the next 15 falling edges capture bits 14..0. `rx_pcm` receives bits 15..3 and `rx_vol` receives bits 2..0.
- R5: `rx_valid` goes high at the falling edge that captures bit 0 and stays high for exactly one clock period. `rx_pcm` and `rx_vol` change at that same edge.
- R6: The attenuation code is taken fresh from every received word. Each completed frame replaces `rx_vol` with that frame's bits 2..0.
- R7: If `mute` is high at the frame-start edge, all 16 transmitted bits are zero, whatever the sample is.
- R8: While `pwr_n` is low, `dout_oe` and `dout` are low from the next rising edge on, a frame in progress is abandoned, no new frame starts, no `rx_valid` pulse appears, and `rx_pcm`/`rx_vol` hold their last values.
- R9: Outside the 16 data slots `dout_oe` and `dout` are low. Activity on `din` after the sixteenth receive bit changes neither `rx_pcm`, `rx_vol` nor `rx_valid`.
- R10: `tx_take` is high for the single cycle after a frame-start edge, which tells the source that the sample was taken. It stays low otherwise.
- R11: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, 256 cycles per frame |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_n | input | 1 | Active-low power-down |
| mute | input | 1 | High forces a zero transmit word |
| fsx | input | 1 | Transmit frame sync |
| tx_sample | input | 13 | Converted sample to send |
| tx_take | output | 1 | One-cycle pulse when the sample is taken |
| dout | output | 1 | Serial transmit data |
| dout_oe | output | 1 | Output driver enable; low means the pad is released |
| fsr | input | 1 | Receive frame sync |
| din | input | 1 | Serial receive data |
| rx_pcm | output | 13 | Received PCM sample |
| rx_vol | output | 3 | Received attenuation code, 0 loudest, 7 softest |
| rx_valid | output | 1 | One-cycle pulse when a word is complete |

## Verification
Transmit results appear at the rising edge where the sync is first seen high. Bit 15 and `tx_take` are due right after that edge, and bit k after 15-k more rising edges. The enable drops at the seventeenth edge. Receive results change at falling edges. The word completes at the sixteenth falling edge after the sync is seen, so the bench checks `rx_valid`, `rx_pcm` and `rx_vol` after the rising edge that falls between that edge and the next falling edge. The bench drives transmit inputs just after falling edges and receive inputs just after rising edges, and it samples two time units after each rising edge, so every check lands on a settled value.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
    typedef enum logic {TX_IDLE = 1'b0, TX_SHIFT = 1'b1} tx_state_e;
    typedef enum logic {RX_IDLE = 1'b0, RX_SHIFT = 1'b1} rx_state_e;
endpackage

// File: rtl/pcm_sync_edge.sv
module pcm_sync_edge #(
    parameter bit NEG_EDGE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic sync_rise
);
    logic sync_q;

    generate
        if (NEG_EDGE) begin : g_fall
            always_ff @(negedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= 1'b0;
                else        sync_q <= sync_in;
            end
        end else begin : g_rise
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= 1'b0;
                else        sync_q <= sync_in;
            end
        end
    endgenerate

    assign sync_rise = sync_in & ~sync_q;
endmodule

// File: rtl/pcm_tx_fsm.sv
module pcm_tx_fsm
    import pcm_port_pkg::*;
#(
    parameter int PCM_W = 13,
    parameter int VOL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_n,
    input  logic             start,
    input  logic             mute,
    input  logic [PCM_W-1:0] tx_sample,
    output logic             dout,
    output logic             dout_oe,
    output logic             tx_take
);
    localparam int WORD_W = PCM_W + VOL_W;
    localparam int CNT_W  = $clog2(WORD_W);

    tx_state_e          state, state_nx;
    logic [WORD_W-1:0]  shreg;
    logic [WORD_W-1:0]  load_word;
    logic [CNT_W-1:0]   cnt;
    logic               last_bit;

    assign load_word = mute ? '0 : {tx_sample, {VOL_W{1'b0}}};
    assign last_bit  = (cnt == CNT_W'(WORD_W - 1));

    always_comb begin
        state_nx = state;
        unique case (state)
            TX_IDLE:  if (pwr_n && start) state_nx = TX_SHIFT;
            TX_SHIFT: if (!pwr_n || last_bit) state_nx = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            cnt     <= '0;
            dout    <= 1'b0;
            dout_oe <= 1'b0;
            tx_take <= 1'b0;
        end else begin
            tx_take <= 1'b0;
            unique case (state)
                TX_IDLE: begin
                    if (pwr_n && start) begin
                        dout    <= load_word[WORD_W-1];
                        shreg   <= load_word << 1;
                        cnt     <= '0;
                        dout_oe <= 1'b1;
                        tx_take <= 1'b1;
                    end else begin
                        dout    <= 1'b0;
                        dout_oe <= 1'b0;
                    end
                end
                TX_SHIFT: begin
                    if (!pwr_n || last_bit) begin
                        dout    <= 1'b0;
                        dout_oe <= 1'b0;
                    end else begin
                        dout  <= shreg[WORD_W-1];
                        shreg <= shreg << 1;
                        cnt   <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/pcm_rx_fsm.sv
module pcm_rx_fsm
    import pcm_port_pkg::*;
#(
    parameter int PCM_W = 13,
    parameter int VOL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_n,
    input  logic             start,
    input  logic             din,
    output logic [PCM_W-1:0] rx_pcm,
    output logic [VOL_W-1:0] rx_vol,
    output logic             rx_valid
);
    localparam int WORD_W = PCM_W + VOL_W;
    localparam int CNT_W  = $clog2(WORD_W);

    rx_state_e          state, state_nx;
    logic [WORD_W-2:0]  shreg;
    logic [WORD_W-1:0]  next_word;
    logic [CNT_W-1:0]   cnt;
    logic               last_bit;

    assign next_word = {shreg, din};
    assign last_bit  = (cnt == CNT_W'(WORD_W - 2));

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE:  if (pwr_n && start) state_nx = RX_SHIFT;
            RX_SHIFT: if (!pwr_n || last_bit) state_nx = RX_IDLE;
        endcase
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nx;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            cnt      <= '0;
            rx_pcm   <= '0;
            rx_vol   <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    if (pwr_n && start) begin
                        shreg <= (WORD_W-1)'(din);
                        cnt   <= '0;
                    end
                end
                RX_SHIFT: begin
                    if (pwr_n) begin
                        shreg <= next_word[WORD_W-2:0];
                        cnt   <= cnt + 1'b1;
                        if (last_bit) begin
                            rx_pcm   <= next_word[WORD_W-1:VOL_W];
                            rx_vol   <= next_word[VOL_W-1:0];
                            rx_valid <= 1'b1;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port #(
    parameter int PCM_W = 13,
    parameter int VOL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_n,
    input  logic             mute,
    input  logic             fsx,
    input  logic [PCM_W-1:0] tx_sample,
    output logic             tx_take,
    output logic             dout,
    output logic             dout_oe,
    input  logic             fsr,
    input  logic             din,
    output logic [PCM_W-1:0] rx_pcm,
    output logic [VOL_W-1:0] rx_vol,
    output logic             rx_valid
);
    logic fsx_rise;
    logic fsr_rise;

    pcm_sync_edge #(.NEG_EDGE(1'b0)) u_fsx_edge (
        .clk(clk), .rst_n(rst_n), .sync_in(fsx), .sync_rise(fsx_rise)
    );

    pcm_sync_edge #(.NEG_EDGE(1'b1)) u_fsr_edge (
        .clk(clk), .rst_n(rst_n), .sync_in(fsr), .sync_rise(fsr_rise)
    );

    pcm_tx_fsm #(.PCM_W(PCM_W), .VOL_W(VOL_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .start(fsx_rise),
        .mute(mute), .tx_sample(tx_sample),
        .dout(dout), .dout_oe(dout_oe), .tx_take(tx_take)
    );

    pcm_rx_fsm #(.PCM_W(PCM_W), .VOL_W(VOL_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .start(fsr_rise),
        .din(din), .rx_pcm(rx_pcm), .rx_vol(rx_vol), .rx_valid(rx_valid)
    );
endmodule

// File: rtl/pcm_serial_port_chk.sv
module pcm_serial_port_chk (
    input logic clk,
    input logic rst_n,
    input logic pwr_n,
    input logic mute,
    input logic dout,
    input logic dout_oe,
    input logic tx_take,
    input logic rx_valid
);
    logic [5:0] oe_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              oe_run <= '0;
        else if (!dout_oe)       oe_run <= '0;
        else if (oe_run != 6'h3F) oe_run <= oe_run + 1'b1;
    end

    AST_PD_RELEASES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_n |=> !dout_oe); // R8

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> !dout); // R9

    AST_OE_SPAN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        oe_run <= 6'd16); // R3

    AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take |=> !tx_take); // R10

    AST_TAKE_WITH_OE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take |-> dout_oe); // R10

    AST_MUTE_FIRST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dout_oe) && $past(mute)) |-> !dout); // R7

    AST_RX_VALID_SINGLE: assert property (@(negedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R5
endmodule

bind pcm_serial_port pcm_serial_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .mute(mute),
    .dout(dout), .dout_oe(dout_oe), .tx_take(tx_take), .rx_valid(rx_valid)
);

// File: tb/pcm_serial_port_tb.sv
module pcm_serial_port_tb_top;
    localparam int CLK_P    = 10;
    localparam int FRAME    = 256;
    localparam int NVEC     = 7;
    localparam int PD_NONE  = 63;

    // {sample[12:0], mute, rx word[15:0], power-down cycle[5:0]}
    localparam logic [35:0] VEC [0:NVEC-1] = '{
        {13'h1ABC, 1'b0, 16'hA5C3, 6'd63},
        {13'h0001, 1'b0, 16'h0007, 6'd63},
        {13'h1555, 1'b1, 16'hFFF8, 6'd63},
        {13'h0AAA, 1'b0, 16'h8001, 6'd63},
        {13'h1234, 1'b0, 16'h1235, 6'd5},
        {13'h0F0F, 1'b0, 16'h3C3A, 6'd0},
        {13'h1FFF, 1'b0, 16'h0004, 6'd63}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_n = 1'b1;
    logic        mute = 1'b0;
    logic        fsx = 1'b0;
    logic [12:0] tx_sample = '0;
    logic        tx_take;
    logic        dout;
    logic        dout_oe;
    logic        fsr = 1'b0;
    logic        din = 1'b0;
    logic [12:0] rx_pcm;
    logic [2:0]  rx_vol;
    logic        rx_valid;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;
    logic [12:0] exp_pcm = '0;
    logic [2:0]  exp_vol = '0;

    always #(CLK_P/2) clk = ~clk;

    pcm_serial_port dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .mute(mute), .fsx(fsx),
        .tx_sample(tx_sample), .tx_take(tx_take), .dout(dout), .dout_oe(dout_oe),
        .fsr(fsr), .din(din), .rx_pcm(rx_pcm), .rx_vol(rx_vol), .rx_valid(rx_valid)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_frame(input logic [12:0] smp, input logic mu,
                             input logic [15:0] rw, input int pd);
        logic [15:0] tw;
        int pdc;
        bit exp_oe;
        bit exp_v;
        tw  = mu ? 16'h0000 : {smp, 3'b000};
        pdc = (pd == PD_NONE) ? FRAME + 1 : pd;
        for (int c = 0; c < FRAME; c++) begin
            @(negedge clk); #1;
            fsx       = (c < 4);
            pwr_n     = (c < pdc);
            tx_sample = smp;
            mute      = mu;
            @(posedge clk); #1;
            fsr = (c < 4);
            din = (c < 16) ? rw[15-c] : (c[0] ^ c[3]);
            #1;
            exp_oe = (c < 16) && (c < pdc);
            if (c <= 17 || c == 128) begin
                // R1 bit order, R2 zero pad, R7 mute, R8 power-down, R9 idle slots
                chk(mu ? "R7" : (c >= 13 && c < 16 ? "R2" : (c >= 16 ? "R9" : "R1")),
                    "dout", 32'(dout), 32'(exp_oe ? tw[15-c] : 1'b0));
                chk(c < pdc ? "R3" : "R8", "dout_oe", 32'(dout_oe), 32'(exp_oe));
            end
            if (c <= 1)
                chk("R10", "tx_take", 32'(tx_take), 32'((c == 0) && (pdc > 0)));
            exp_v = (c == 16) && (pdc >= 16);
            if (exp_v) begin
                exp_pcm = rw[15:3];
                exp_vol = rw[2:0];
            end
            if ((c >= 14 && c <= 18) || c == 255)
                chk(pdc < 16 ? "R8" : "R5", "rx_valid", 32'(rx_valid), 32'(exp_v));
            if (c == 16) begin
                chk("R4", "rx_pcm", 32'(rx_pcm), 32'(exp_pcm));
                chk("R6", "rx_vol", 32'(rx_vol), 32'(exp_vol));
            end
            if (c == 255) begin
                chk("R9", "rx_pcm held", 32'(rx_pcm), 32'(exp_pcm));
                chk("R9", "rx_vol held", 32'(rx_vol), 32'(exp_vol));
            end
        end
        pwr_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R11 reset state
        chk("R11", "dout_oe in reset", 32'(dout_oe), 32'd0);
        chk("R11", "dout in reset", 32'(dout), 32'd0);
        chk("R11", "tx_take in reset", 32'(tx_take), 32'd0);
        chk("R11", "rx_valid in reset", 32'(rx_valid), 32'd0);
        chk("R11", "rx_pcm in reset", 32'(rx_pcm), 32'd0);
        chk("R11", "rx_vol in reset", 32'(rx_vol), 32'd0);
        @(negedge clk); #1;
        rst_n = 1'b1;
        repeat (4) @(posedge clk);

        for (int v = 0; v < NVEC; v++)
            run_frame(VEC[v][35:23], VEC[v][22], VEC[v][21:6], int'(VEC[v][5:0]));

        // Directed: reset in the middle of a transmit frame clears the output (R11)
        @(negedge clk); #1;
        fsx = 1'b1;
        tx_sample = 13'h1FFF;
        mute = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        chk("R3", "dout_oe mid frame", 32'(dout_oe), 32'd1);
        rst_n = 1'b0;
        #1;
        chk("R11", "dout_oe after reset", 32'(dout_oe), 32'd0);
        chk("R11", "dout after reset", 32'(dout), 32'd0);
        chk("R11", "rx_pcm after reset", 32'(rx_pcm), 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule